// File: doc/BRIEF.md
# UART Programmer Register Block with Receive Buffer

This block holds the registers that software sees in a UART, together with the receive buffer. The serial side is handled elsewhere. Received bytes come in as a stream with a valid strobe and leave through reads of the data word. The block drives a ready signal that shows whether it can take another byte. A write to the data word sends the low byte out as a one-cycle transmit strobe and sets the transmit interrupt. The block also holds the baud-divisor, line-control, control, FIFO-level, interrupt-mask and DMA-control values. It provides raw, masked and clear access to the two interrupt sources, and one interrupt line follows the masked status.

The buffer has two modes. With the FIFO-enable bit of line control set, it holds up to 16 bytes. With that bit clear, it holds one byte. The receive interrupt rises when a byte lands in an empty buffer and falls when a read drains the buffer. A fixed set of identification bytes can be read in the top 32 bytes of the 4 KB window. Reads return data combinationally while the request is present. Writes, and the pop caused by a data read, take effect at the clock edge.

Top module: `uart_regif`

## Requirements
- R1: After reset, flags (word 6) read 0x90, control (word 12) reads 0x300, level select (word 13) reads 0x12, and every other register, the raw status and `irq` are 0.
- R2: The buffer limit is 16 entries when line control (word 11) bit 4 is 1 and 1 entry when it is 0. `rx_ready` is high exactly when the stored count is below the limit.
- R3: A byte offered with `rx_valid` while `rx_ready` is low is dropped, and the buffer contents do not change.
- R4: Flags word bits: bit 7 transmit-empty is always 1, bit 5 transmit-full is always 0, bit 4 receive-empty is 1 when the count is 0, and bit 6 receive-full is 1 when the count has reached the limit.
- R5: A read of word 0 returns the oldest stored byte in bits 7:0 and removes it. Bytes come out in arrival order, and a read of an empty buffer removes nothing.
- R6: Raw status (word 15) bit 4 sets when a push brings the count to 1. It clears when a data read leaves the count at 0.
- R7: A write to word 0 gives `tx_valid` high for exactly one cycle after the write edge, with `tx_byte` equal to the written bits 7:0, and sets raw status bit 5.
- R8: A write to word 17 clears each raw status bit whose written bit is 1. A set event in the same cycle takes precedence.
- R9: Mask is word 14 (bits 10:0). Masked status (word 16) equals raw AND mask, and `irq` is high exactly when that result is nonzero.
- R10: Words 8, 9, 10, 11, 12, 13 and 18 read back the last value written, truncated to 8, 16, 6, 8, 16, 6 and 3 bits.
- R11: Byte offsets 0xFE0 to 0xFFC read the bytes 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in order.
- R12: Writes to words 6, 15 and 16 change nothing, and reads of words that are not mapped return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request (a data-word read pops) |
| addr | input | 12 | Byte offset within the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Buffer can accept a byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is the boundary between the two buffer limits. It needs the 16-entry buffer filled with line control set, a seventeenth byte offered so it is dropped, and then the whole buffer drained in order until the receive interrupt falls on the last read. The bench builds this with a series of single-cycle pushes and data reads. It checks `rx_ready`, the full and empty flags and the raw status bit at each end. Single-entry mode then repeats the same drop at a limit of one.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned W_DATA  = 0;
  localparam int unsigned W_FLAG  = 6;
  localparam int unsigned W_LPDIV = 8;
  localparam int unsigned W_IDIV  = 9;
  localparam int unsigned W_FDIV  = 10;
  localparam int unsigned W_LINE  = 11;
  localparam int unsigned W_CTRL  = 12;
  localparam int unsigned W_LVL   = 13;
  localparam int unsigned W_MASK  = 14;
  localparam int unsigned W_RAW   = 15;
  localparam int unsigned W_MSK   = 16;
  localparam int unsigned W_CLR   = 17;
  localparam int unsigned W_DMA   = 18;

  localparam int unsigned RX_INT_BIT = 4;
  localparam int unsigned TX_INT_BIT = 5;
  localparam int unsigned FIFO_EN_BIT = 4;

  localparam logic [15:0] CTRL_RST = 16'h0300;
  localparam logic [5:0]  LVL_RST  = 6'h12;

  function automatic logic [7:0] id_byte(input logic [2:0] sel);
    logic [7:0] v;
    case (sel)
      3'd0: v = 8'h11;
      3'd1: v = 8'h10;
      3'd2: v = 8'h14;
      3'd3: v = 8'h00;
      3'd4: v = 8'h0D;
      3'd5: v = 8'hF0;
      3'd6: v = 8'h05;
      default: v = 8'hB1;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep_mode,
  input  logic              push_req,
  input  logic [BYTE_W-1:0] din,
  input  logic              pop_req,
  output logic [BYTE_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_nxt,
  output logic [CNT_W-1:0]  limit,
  output logic              in_ready,
  output logic              push_fire,
  output logic              pop_fire
);
  logic [BYTE_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;

  always_comb begin
    limit     = deep_mode ? CNT_W'(DEPTH) : CNT_W'(1);
    in_ready  = (count < limit);
    push_fire = push_req && in_ready;
    pop_fire  = pop_req && (count != '0);
    head      = store[rd_ptr];
    wr_ptr_nxt = push_fire ? wr_ptr + PTR_W'(1) : wr_ptr;
    rd_ptr_nxt = pop_fire  ? rd_ptr + PTR_W'(1) : rd_ptr;
    count_nxt = count;
    if (push_fire && !pop_fire) count_nxt = count + CNT_W'(1);
    else if (!push_fire && pop_fire) count_nxt = count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_fire && (wr_ptr == PTR_W'(g))) store[g] <= din;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && (count >= limit) && !pop_req) |=> $stable(count));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && (count == '0) && !push_req) |=> (count == '0));
endmodule

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
  import uart_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned MASK_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_set,
  input  logic              rx_clr,
  output logic [7:0]        lpdiv_q,
  output logic [15:0]       idiv_q,
  output logic [5:0]        fdiv_q,
  output logic [7:0]        line_q,
  output logic [15:0]       ctrl_q,
  output logic [5:0]        lvl_q,
  output logic [MASK_W-1:0] mask_q,
  output logic [2:0]        dma_q,
  output logic              raw_rx_q,
  output logic              raw_tx_q,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  logic wr_data, wr_clr;
  logic raw_rx_d, raw_tx_d;

  always_comb begin
    wr_data  = wr_en && (wr_idx == IDX_W'(W_DATA));
    wr_clr   = wr_en && (wr_idx == IDX_W'(W_CLR));
    raw_rx_d = raw_rx_q;
    raw_tx_d = raw_tx_q;
    if (wr_clr && wdata[RX_INT_BIT]) raw_rx_d = 1'b0;
    if (wr_clr && wdata[TX_INT_BIT]) raw_tx_d = 1'b0;
    if (rx_clr) raw_rx_d = 1'b0;
    if (rx_set) raw_rx_d = 1'b1;
    if (wr_data) raw_tx_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_rx_q <= 1'b0;
      raw_tx_q <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      raw_rx_q <= raw_rx_d;
      raw_tx_q <= raw_tx_d;
      tx_valid <= wr_data;
      if (wr_data) tx_byte <= wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpdiv_q <= '0;
      idiv_q  <= '0;
      fdiv_q  <= '0;
      line_q  <= '0;
      ctrl_q  <= CTRL_RST;
      lvl_q   <= LVL_RST;
      mask_q  <= '0;
      dma_q   <= '0;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(W_LPDIV)) lpdiv_q <= wdata[7:0];
      if (wr_idx == IDX_W'(W_IDIV))  idiv_q  <= wdata[15:0];
      if (wr_idx == IDX_W'(W_FDIV))  fdiv_q  <= wdata[5:0];
      if (wr_idx == IDX_W'(W_LINE))  line_q  <= wdata[7:0];
      if (wr_idx == IDX_W'(W_CTRL))  ctrl_q  <= wdata[15:0];
      if (wr_idx == IDX_W'(W_LVL))   lvl_q   <= wdata[5:0];
      if (wr_idx == IDX_W'(W_MASK))  mask_q  <= wdata[MASK_W-1:0];
      if (wr_idx == IDX_W'(W_DMA))   dma_q   <= wdata[2:0];
    end
  end

  // R7
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> (tx_valid && raw_tx_q));

  // R7
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !wr_data) |=> !tx_valid);

  // R8
  clr_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && wdata[RX_INT_BIT] && !rx_set) |=> !raw_rx_q);
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned MASK_W = 11,
  localparam int unsigned IDX_W = ADDR_W - 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  logic [IDX_W-1:0]  idx;
  logic              in_id_area;
  logic              pop_req;
  logic [BYTE_W-1:0] head;
  logic [CNT_W-1:0]  count, count_nxt, limit;
  logic              push_fire, pop_fire;
  logic              rx_set, rx_clr;
  logic [7:0]        lpdiv_q, line_q;
  logic [15:0]       idiv_q, ctrl_q;
  logic [5:0]        fdiv_q, lvl_q;
  logic [MASK_W-1:0] mask_q, raw_vec, msk_vec;
  logic [2:0]        dma_q;
  logic              raw_rx_q, raw_tx_q;
  logic [7:0]        flag_vec;

  assign idx        = addr[ADDR_W-1:2];
  assign in_id_area = (addr >= ADDR_W'(12'hFE0));
  assign pop_req    = rd_en && !in_id_area && (idx == IDX_W'(W_DATA));
  assign rx_set     = push_fire && (count_nxt == CNT_W'(1));
  assign rx_clr     = pop_fire && (count_nxt == '0);

  uart_rx_buf #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .deep_mode(line_q[FIFO_EN_BIT]),
    .push_req(rx_valid), .din(rx_byte), .pop_req(pop_req),
    .head(head), .count(count), .count_nxt(count_nxt), .limit(limit),
    .in_ready(rx_ready), .push_fire(push_fire), .pop_fire(pop_fire)
  );

  uart_ctl_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYTE_W(BYTE_W), .MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !in_id_area), .wr_idx(idx),
    .wdata(wdata), .rx_set(rx_set), .rx_clr(rx_clr),
    .lpdiv_q(lpdiv_q), .idiv_q(idiv_q), .fdiv_q(fdiv_q), .line_q(line_q),
    .ctrl_q(ctrl_q), .lvl_q(lvl_q), .mask_q(mask_q), .dma_q(dma_q),
    .raw_rx_q(raw_rx_q), .raw_tx_q(raw_tx_q),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  always_comb begin
    raw_vec = '0;
    raw_vec[RX_INT_BIT] = raw_rx_q;
    raw_vec[TX_INT_BIT] = raw_tx_q;
    msk_vec = raw_vec & mask_q;
    irq = |msk_vec;
    flag_vec = 8'h00;
    flag_vec[7] = 1'b1;
    flag_vec[6] = (count >= limit);
    flag_vec[5] = 1'b0;
    flag_vec[4] = (count == '0);
  end

  always_comb begin
    rdata = '0;
    if (in_id_area) begin
      rdata = DATA_W'(id_byte(addr[4:2]));
    end else begin
      case (idx)
        IDX_W'(W_DATA):  rdata = DATA_W'(head);
        IDX_W'(W_FLAG):  rdata = DATA_W'(flag_vec);
        IDX_W'(W_LPDIV): rdata = DATA_W'(lpdiv_q);
        IDX_W'(W_IDIV):  rdata = DATA_W'(idiv_q);
        IDX_W'(W_FDIV):  rdata = DATA_W'(fdiv_q);
        IDX_W'(W_LINE):  rdata = DATA_W'(line_q);
        IDX_W'(W_CTRL):  rdata = DATA_W'(ctrl_q);
        IDX_W'(W_LVL):   rdata = DATA_W'(lvl_q);
        IDX_W'(W_MASK):  rdata = DATA_W'(mask_q);
        IDX_W'(W_RAW):   rdata = DATA_W'(raw_vec);
        IDX_W'(W_MSK):   rdata = DATA_W'(msk_vec);
        IDX_W'(W_DMA):   rdata = DATA_W'(dma_q);
        default:         rdata = '0;
      endcase
    end
  end

  // R6
  rx_int_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && (count == CNT_W'(1)) && !push_fire) |=> !raw_rx_q);

  // R6
  rx_int_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && (count == '0)) |=> raw_rx_q);
endmodule

// File: tb/uart_regif_bench.sv
module uart_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_byte;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regif u_uart_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int word, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'(word * 4); wdata = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd(input int word, output logic [31:0] v);
    rd_a(12'(word * 4), v);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6, v);  chk("R1 flags", v, 32'h90);
    rd(12, v); chk("R1 ctrl", v, 32'h300);
    rd(13, v); chk("R1 level", v, 32'h12);
    rd(15, v); chk("R1 raw", v, 0);
    rd(14, v); chk("R1 mask", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    chk("R2 ready single", 32'(rx_ready), 1);
    push(8'hA5);
    chk("R2 ready full", 32'(rx_ready), 0);
    rd(6, v); chk("R4 flags full", v, 32'hC0);
    rd(15, v); chk("R6 raw rx set", v, 32'h10);
    push(8'h3C);
    rd(0, v); chk("R3 drop single / R5 data", v, 32'hA5);
    rd(15, v); chk("R6 raw rx cleared", v, 0);
    rd(6, v); chk("R4 flags empty", v, 32'h90);
    chk("R2 ready after read", 32'(rx_ready), 1);
  endtask

  task automatic t_deep;
    logic [31:0] v;
    wr(11, 32'h10);
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    chk("R2 ready at 16", 32'(rx_ready), 0);
    rd(6, v); chk("R4 deep full", v, 32'hC0);
    push(8'hEE);
    for (int i = 0; i < 16; i++) begin
      rd(0, v); chk("R5 order / R3 drop deep", v, 32'(8'h40 + i));
      if (i == 14) begin
        rd(15, v); chk("R6 raw rx held at 1", v, 32'h10);
      end
    end
    rd(15, v); chk("R6 raw rx dropped", v, 0);
    rd(6, v); chk("R4 deep empty", v, 32'h90);
    push(8'h77);
    rd(6, v); chk("R4 deep one", v, 32'h80);
    rd(0, v); chk("R5 single after drain", v, 32'h77);
    rd(0, v);
    rd(6, v); chk("R5 empty read no pop", v, 32'h90);
    wr(11, 32'h0);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h000; wdata = 32'h1234_56C3;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 tx_valid", 32'(tx_valid), 1);
    chk("R7 tx_byte", 32'(tx_byte), 32'hC3);
    @(negedge clk);
    chk("R7 tx_valid one cycle", 32'(tx_valid), 0);
    rd(15, v); chk("R7 raw tx", v, 32'h20);
    chk("R9 irq masked off", 32'(irq), 0);
    wr(14, 32'h20);
    chk("R9 irq on", 32'(irq), 1);
    rd(16, v); chk("R9 masked", v, 32'h20);
    push(8'h01);
    rd(16, v); chk("R9 masked rx not enabled", v, 32'h20);
    wr(17, 32'h10);
    rd(15, v); chk("R8 clear rx only", v, 32'h20);
    wr(17, 32'h20);
    rd(15, v); chk("R8 clear tx", v, 0);
    chk("R9 irq off", 32'(irq), 0);
    rd(0, v);
    wr(14, 32'hFFFF_FFFF);
    rd(14, v); chk("R9 mask width", v, 32'h7FF);
    wr(14, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(8, '1);  rd(8, v);  chk("R10 lpdiv", v, 32'hFF);
    wr(9, '1);  rd(9, v);  chk("R10 idiv", v, 32'hFFFF);
    wr(10, '1); rd(10, v); chk("R10 fdiv", v, 32'h3F);
    wr(11, '1); rd(11, v); chk("R10 line", v, 32'hFF);
    wr(11, 0);
    wr(12, 32'hABCD1234); rd(12, v); chk("R10 ctrl", v, 32'h1234);
    wr(13, 32'h2D); rd(13, v); chk("R10 level", v, 32'h2D);
    wr(18, '1); rd(18, v); chk("R10 dma", v, 32'h7);
  endtask

  task automatic t_id;
    logic [31:0] v;
    logic [7:0] exp_id [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rd_a(12'(12'hFE0 + 4 * i), v); chk("R11 id", v, 32'(exp_id[i]));
    end
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wr(6, '1);  rd(6, v);  chk("R12 flags ro", v, 32'h90);
    wr(15, '1); rd(15, v); chk("R12 raw ro", v, 0);
    wr(16, '1); rd(16, v); chk("R12 masked ro", v, 0);
    chk("R12 irq", 32'(irq), 0);
    rd(3, v); chk("R12 unmapped", v, 0);
    rd(40, v); chk("R12 unmapped high", v, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_single;
    t_deep;
    t_tx;
    t_regs;
    t_id;
    t_ignored;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule